// File: doc/BRIEF.md
# Video Stream Marker Regenerator

This block sits in an 8-bit pixel stream that uses the AXI4-Stream handshake. On the input side, TUSER flags the first pixel of a frame and TLAST flags the last pixel of a line. A filter further along the path (represented here only by a pixel inversion) delays the picture by a fixed number of rows and columns. Copying the incoming markers would therefore place them on the wrong pixels. The block rebuilds the frame and line markers from its own row and column position counters, which are offset by a compile-time delay. As a result, the markers for the tail of one frame can leave the block while the pixels of the next frame are arriving.

Every accepted input beat yields exactly one output beat, in order. The block adds no flush cycles at line or frame ends. Byte-enable, position-enable, stream-ID and routing fields travel with their beat unchanged. The output stage is a two-entry skid register. Input readiness comes from registered state only, so the block sustains one beat per clock under backpressure without a combinational ready path.

Top module: `vid_marker_regen`

## Requirements
- R1: Each input handshake (in_valid and in_ready high at a rising edge) yields exactly one output handshake later. Beats leave in arrival order and none are lost or duplicated.
- R2: Output pixel equals 255 minus the input pixel of the same beat.
- R3: out_keep, out_strb, out_id and out_dest equal the values presented with the producing input beat.
- R4: A column position is kept per beat. When the previous accepted beat had in_eol=1, the next column is 0; otherwise the next column is the current column plus 1 (13 bits, wrapping). out_eol is 1 exactly when the beat's column equals DELAY-1.
- R5: out_sof is 1 exactly when both the beat's row and column equal DELAY.
- R6: A row position is kept per beat. When the current beat has in_sof=1, the next row is 0. Otherwise, when the previous accepted beat had in_eol=1, the next row is the current row plus 1; in all other cases it is unchanged. Positions change only on input handshakes.
- R7: After reset, row and column are 0 and the "previous beat ended a line" flag is 1. With DELAY=2 and no input markers, the first three outputs therefore carry out_eol = 0, 0, 1.
- R8: While out_valid=1 and out_ready=0, out_valid stays 1 and all output fields stay unchanged into the next cycle.
- R9: If out_ready is high in a cycle, in_ready is high in the following cycle. With out_ready held high, in_ready never drops, giving one beat per clock.
- R10: While rst_n is low, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept an input beat |
| in_data | input | 8 | Input pixel |
| in_sof | input | 1 | Input start-of-frame marker (TUSER) |
| in_eol | input | 1 | Input end-of-line marker (TLAST) |
| in_keep | input | 1 | Input byte enable |
| in_strb | input | 1 | Input position enable |
| in_id | input | 1 | Input stream ID |
| in_dest | input | 1 | Input routing field |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can accept |
| out_data | output | 8 | Inverted pixel |
| out_sof | output | 1 | Regenerated start-of-frame marker |
| out_eol | output | 1 | Regenerated end-of-line marker |
| out_keep | output | 1 | Byte enable of the beat |
| out_strb | output | 1 | Position enable of the beat |
| out_id | output | 1 | Stream ID of the beat |
| out_dest | output | 1 | Routing field of the beat |

## Verification
The embedded properties assume the upstream source never withdraws in_valid before it is accepted and changes no beat fields while waiting. The stimulus meets this by holding each beat until its handshake completes, and it inserts random idle cycles only between beats. The properties also assume that out_ready may drop in any cycle. The stimulus therefore stalls the output at random, and it includes a full-rate phase with readiness held high. Input frames are well formed, with one in_sof per frame and one in_eol per line, so the rebuilt markers land on visible rows and columns for the chosen delay.

// File: rtl/vmr_pkg.sv
package vmr_pkg;

  // Occupancy of the two-entry output skid stage
  typedef enum logic [1:0] {
    OCC_EMPTY = 2'd0,
    OCC_MAIN  = 2'd1,
    OCC_BOTH  = 2'd2
  } occ_e;

  // Regenerated marker pair attached to each beat
  typedef struct packed {
    logic sof;
    logic eol;
  } mark_t;

endpackage

// File: rtl/vmr_pos_track.sv
module vmr_pos_track #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             beat_sof,
  input  logic             beat_eol,
  output logic [CNT_W-1:0] col,
  output logic [CNT_W-1:0] row,
  output logic             prev_eol
);

  logic [CNT_W-1:0] col_nxt;
  logic [CNT_W-1:0] row_nxt;
  logic             prev_eol_nxt;

  // Next-state logic: positions move only on an accepted beat
  always_comb begin
    col_nxt      = col;
    row_nxt      = row;
    prev_eol_nxt = prev_eol;
    if (step) begin
      if (prev_eol) begin
        col_nxt = '0;
      end else begin
        col_nxt = col + CNT_W'(1);
      end
      if (beat_sof) begin
        row_nxt = '0;
      end else if (prev_eol) begin
        row_nxt = row + CNT_W'(1);
      end
      prev_eol_nxt = beat_eol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col      <= '0;
      row      <= '0;
      prev_eol <= 1'b1;
    end else if (step) begin
      col      <= col_nxt;
      row      <= row_nxt;
      prev_eol <= prev_eol_nxt;
    end
  end

  AST_COL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && prev_eol) |=> (col == '0)); // R4

  AST_ROW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && beat_sof) |=> (row == '0)); // R6

  AST_POS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step) |=> ($stable(col) && $stable(row) && $stable(prev_eol))); // R6

  AST_FLAG_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (prev_eol == $past(beat_eol))); // R4

endmodule

// File: rtl/vmr_beat_form.sv
module vmr_beat_form
  import vmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 13,
  parameter int DELAY  = 2
) (
  input  logic [DATA_W-1:0] pix_in,
  input  logic [CNT_W-1:0]  col,
  input  logic [CNT_W-1:0]  row,
  output logic [DATA_W-1:0] pix_out,
  output mark_t             mark
);

  localparam logic [CNT_W-1:0] EOL_COL  = CNT_W'(DELAY - 1);
  localparam logic [CNT_W-1:0] SOF_POS  = CNT_W'(DELAY);
  localparam logic [DATA_W-1:0] PIX_MAX = {DATA_W{1'b1}};

  // Stand-in filter: full-scale minus the pixel
  always_comb begin
    pix_out = PIX_MAX - pix_in;
  end

  // Markers rebuilt from the delayed position
  always_comb begin
    mark.eol = (col == EOL_COL);
    mark.sof = (row == SOF_POS) && (col == SOF_POS);
  end

endmodule

// File: rtl/vmr_skid.sv
module vmr_skid
  import vmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_bits,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_bits
);

  occ_e         occ_q;
  occ_e         occ_nxt;
  logic [W-1:0] main_q;
  logic [W-1:0] spare_q;
  logic         take;
  logic         main_en;
  logic         main_from_spare;
  logic         spare_en;

  assign up_ready = (occ_q != OCC_BOTH);
  assign dn_valid = (occ_q != OCC_EMPTY);
  assign dn_bits  = main_q;
  assign take     = up_valid && up_ready;

  // Next-state and clock-enable decode
  always_comb begin
    occ_nxt         = occ_q;
    main_en         = 1'b0;
    main_from_spare = 1'b0;
    spare_en        = 1'b0;
    unique case (occ_q)
      OCC_EMPTY: begin
        if (take) begin
          occ_nxt = OCC_MAIN;
          main_en = 1'b1;
        end
      end
      OCC_MAIN: begin
        if (dn_ready) begin
          if (take) begin
            main_en = 1'b1;
          end else begin
            occ_nxt = OCC_EMPTY;
          end
        end else if (take) begin
          occ_nxt  = OCC_BOTH;
          spare_en = 1'b1;
        end
      end
      OCC_BOTH: begin
        if (dn_ready) begin
          occ_nxt         = OCC_MAIN;
          main_en         = 1'b1;
          main_from_spare = 1'b1;
        end
      end
      default: occ_nxt = OCC_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= OCC_EMPTY;
    end else begin
      occ_q <= occ_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= '0;
    end else if (main_en) begin
      main_q <= main_from_spare ? spare_q : up_bits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spare_q <= '0;
    end else if (spare_en) begin
      spare_q <= up_bits;
    end
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_bits))); // R8

  AST_READY_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    dn_ready |=> up_ready); // R9

  AST_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && dn_valid && !dn_ready) |=> (!up_ready && dn_valid)); // R1

  AST_EMPTY_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!dn_valid && take) |=> (dn_valid && dn_bits == $past(up_bits))); // R1

endmodule

// File: rtl/vid_marker_regen.sv
module vid_marker_regen
  import vmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 13,
  parameter int DELAY  = 2,
  parameter int ID_W   = 1,
  parameter int DEST_W = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_data,
  input  logic                in_sof,
  input  logic                in_eol,
  input  logic [DATA_W/8-1:0] in_keep,
  input  logic [DATA_W/8-1:0] in_strb,
  input  logic [ID_W-1:0]     in_id,
  input  logic [DEST_W-1:0]   in_dest,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_sof,
  output logic                out_eol,
  output logic [DATA_W/8-1:0] out_keep,
  output logic [DATA_W/8-1:0] out_strb,
  output logic [ID_W-1:0]     out_id,
  output logic [DEST_W-1:0]   out_dest
);

  localparam int BYTE_W = DATA_W / 8;
  localparam int MARK_W = $bits(mark_t);
  localparam int BUS_W  = DEST_W + ID_W + 2 * BYTE_W + MARK_W + DATA_W;

  logic              accept;
  logic [CNT_W-1:0]  col;
  logic [CNT_W-1:0]  row;
  logic              prev_eol;
  logic [DATA_W-1:0] pix_f;
  mark_t             mark_f;
  mark_t             mark_o;
  logic [BUS_W-1:0]  bus_in;
  logic [BUS_W-1:0]  bus_out;

  assign accept = in_valid && in_ready;

  vmr_pos_track #(
    .CNT_W (CNT_W)
  ) i_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (accept),
    .beat_sof (in_sof),
    .beat_eol (in_eol),
    .col      (col),
    .row      (row),
    .prev_eol (prev_eol)
  );

  vmr_beat_form #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .DELAY  (DELAY)
  ) i_form (
    .pix_in  (in_data),
    .col     (col),
    .row     (row),
    .pix_out (pix_f),
    .mark    (mark_f)
  );

  assign bus_in = {in_dest, in_id, in_strb, in_keep, mark_f, pix_f};

  vmr_skid #(
    .W (BUS_W)
  ) i_skid (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_bits  (bus_in),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_bits  (bus_out)
  );

  assign {out_dest, out_id, out_strb, out_keep, mark_o, out_data} = bus_out;
  assign out_sof = mark_o.sof;
  assign out_eol = mark_o.eol;

  AST_RESET_IDLE: assert property (@(posedge clk)
    (!rst_n) |-> (!out_valid && in_ready)); // R10

  AST_FRESH_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (prev_eol && col == '0 && row == '0)); // R7

endmodule

// File: tb/test_vid_marker_regen.sv
module test_vid_marker_regen;

  localparam int CLK_PERIOD = 10;
  localparam int DELAY      = 2;
  localparam int WIDTH      = 6;
  localparam int HEIGHT     = 5;
  localparam int LIMIT      = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready;
  logic [7:0] in_data;
  logic       in_sof, in_eol;
  logic       in_keep, in_strb, in_id, in_dest;
  logic       out_valid, out_ready;
  logic [7:0] out_data;
  logic       out_sof, out_eol;
  logic       out_keep, out_strb, out_id, out_dest;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_marker_regen #(.DELAY(DELAY)) i_vid_marker_regen (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eol(in_eol), .in_keep(in_keep), .in_strb(in_strb),
    .in_id(in_id), .in_dest(in_dest),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eol(out_eol), .out_keep(out_keep),
    .out_strb(out_strb), .out_id(out_id), .out_dest(out_dest)
  );

  int total = 0;
  int bad   = 0;
  int in_cnt = 0;
  int out_cnt = 0;
  int cycles = 0;
  logic done = 1'b0;

  // Expected beat: {data, keep, strb, id, dest, sof, eol}
  logic [13:0] exp_q[$];
  int  m_col = 0, m_row = 0;
  bit  m_prev = 1'b1;

  // Drive variables applied at the falling edge
  logic d_valid = 0, d_sof = 0, d_eol = 0, d_keep = 0, d_strb = 0, d_id = 0, d_dest = 0;
  logic [7:0] d_data = 0;
  int  stall_pct = 0;
  bit  full_rate = 0;
  bit  last_in_hs = 0;
  bit  held = 0;
  logic [13:0] held_bits;
  logic early_eol[$];
  bit  record_eol = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [13:0] cur_out();
    return {out_data, out_keep, out_strb, out_id, out_dest, out_sof, out_eol};
  endfunction

  // Reference position model, R4 R5 R6 R7
  task automatic model_push();
    logic e_eol, e_sof;
    e_eol = (m_col == DELAY - 1);
    e_sof = (m_row == DELAY) && (m_col == DELAY);
    exp_q.push_back({8'(255 - int'(in_data)), in_keep, in_strb, in_id, in_dest, e_sof, e_eol});
    if (in_sof) m_row = 0;
    else if (m_prev) m_row = (m_row + 1) % 8192;
    if (m_prev) m_col = 0;
    else m_col = (m_col + 1) % 8192;
    m_prev = in_eol;
    in_cnt++;
  endtask

  task automatic model_pop();
    logic [13:0] e;
    out_cnt++;
    if (record_eol) early_eol.push_back(out_eol);
    if (exp_q.size() == 0) begin
      check(1'b0, "R1", "output without input", out_cnt, in_cnt);
      return;
    end
    e = exp_q.pop_front();
    check(out_data == e[13:6], "R2", "data", out_data, e[13:6]);
    check({out_keep, out_strb, out_id, out_dest} == e[5:2], "R3", "sideband",
          {out_keep, out_strb, out_id, out_dest}, e[5:2]);
    check(out_eol == e[0], "R4", "eol", out_eol, e[0]);
    check(out_sof == e[1], "R5 R6", "sof", out_sof, e[1]);
  endtask

  task automatic tick();
    @(negedge clk);
    in_valid = d_valid; in_data = d_data; in_sof = d_sof; in_eol = d_eol;
    in_keep = d_keep; in_strb = d_strb; in_id = d_id; in_dest = d_dest;
    out_ready = (stall_pct == 0) ? 1'b1 : (($urandom % 100) >= stall_pct);
    #1;
    if (held) begin
      check(out_valid && cur_out() == held_bits, "R8", "stalled beat held",
            int'(cur_out()), int'(held_bits));
      held = 0;
    end
    if (full_rate) check(in_ready, "R9", "ready at full rate", in_ready, 1);
    last_in_hs = in_valid && in_ready;
    if (last_in_hs) model_push();
    if (out_valid && out_ready) model_pop();
    if (out_valid && !out_ready) begin
      held = 1;
      held_bits = cur_out();
    end
  endtask

  task automatic send(input logic [7:0] pix, input bit sof, input bit eol, input int gap_pct);
    d_valid = 0;
    while (gap_pct != 0 && ($urandom % 100) < gap_pct) tick();
    d_valid = 1; d_data = pix; d_sof = sof; d_eol = eol;
    d_keep = $urandom; d_strb = $urandom; d_id = $urandom; d_dest = $urandom;
    do tick(); while (!last_in_hs);
    d_valid = 0;
  endtask

  task automatic frame(input int gap_pct);
    for (int r = 0; r < HEIGHT; r++)
      for (int c = 0; c < WIDTH; c++)
        send(8'($urandom), (r == 0 && c == 0), (c == WIDTH - 1), gap_pct);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; out_ready = 0; in_data = 0; in_sof = 0; in_eol = 0;
    in_keep = 0; in_strb = 0; in_id = 0; in_dest = 0;
    repeat (3) @(negedge clk);
    check(!out_valid, "R10", "out_valid in reset", out_valid, 0);
    check(in_ready, "R10", "in_ready in reset", in_ready, 1);
    @(negedge clk); rst_n = 1;
    #1;
    check(!out_valid, "R10", "out_valid after release", out_valid, 0);

    // R7: first three outputs with no markers carry eol 0,0,1
    record_eol = 1;
    for (int i = 0; i < 3; i++) send(8'(i * 40), 0, 0, 0);
    d_valid = 0;
    repeat (4) tick();
    record_eol = 0;
    check(early_eol.size() == 3, "R7", "early outputs", early_eol.size(), 3);
    if (early_eol.size() == 3) begin
      check(early_eol[0] == 0, "R7", "eol of beat 0", early_eol[0], 0);
      check(early_eol[1] == 0, "R7", "eol of beat 1", early_eol[1], 0);
      check(early_eol[2] == 1, "R7", "eol of beat 2", early_eol[2], 1);
    end

    // Full-rate frames, R9
    full_rate = 1; stall_pct = 0;
    frame(0); frame(0);
    full_rate = 0;

    // Random gaps and stalls, R1 R8
    stall_pct = 40;
    for (int f = 0; f < 4; f++) frame(30);
    stall_pct = 70;
    frame(10);

    // Drain
    stall_pct = 0; d_valid = 0;
    repeat (20) tick();
    check(in_cnt == out_cnt, "R1", "beat count", out_cnt, in_cnt);
    check(exp_q.size() == 0, "R1", "pending beats", exp_q.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule